// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Interrupt Detection

This block gives software control over sixteen general-purpose pins through a small memory-mapped register set. The data path is 16 bits wide and the byte address is 8 bits. Each pin has its own direction bit. Output levels are changed through a write-one-to-set register and a write-one-to-clear register, so software never has to read, modify and write the output latch. Pin inputs pass through a two-flop synchroniser before software reads them or the interrupt logic uses them.

Each pin can raise an interrupt in one of two modes. In level mode the pin is active-high or active-low. In edge mode it can fire on a rising edge, a falling edge, or both. An interrupt is reported only when the pin's mask bit is clear and its enable bit is set. Latched edge events are acknowledged by writing ones to the clear register. All reported bits are ORed onto one interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` = 0), `pin_out` is 0, the mask register (0x28) reads 0xFFFF, the enable register (0x2C) reads 0, the status register (0x30) reads 0 and `irq` is low.
- R2: The direction register (0x00) reads back its last written value. Bit n set to 1 drives `pin_oe[n]` high (output), and 0 drives it low (input), from the cycle after the write.
- R3: Writing to the set register (0x18) sets the output latch bits written as 1. Writing to the clear register (0x1C) clears the bits written as 1. Bits written as 0 keep their value. The latch is visible on `pin_out` and in the output readback register (0x20) from the cycle after the write.
- R4: The input register (0x14) shows `pin_in` two clock edges after a change, through a two-flop synchroniser.
- R5: A pin with its mode bit (0x04) at 1 is level-sensitive. Polarity bit (0x08) at 1 means active-high and 0 means active-low. The level condition appears in status as soon as the synchronised input satisfies it. It is not latched: it stays while the condition holds, even after a clear, and goes away when the condition ends.
- R6: A pin with its mode bit at 0 is edge-sensitive. Rising-edge enable (0x0C) and falling-edge enable (0x10) act independently. An enabled edge is latched and appears in status three clock edges after the `pin_in` change. An edge whose enable bit is 0 is ignored.
- R7: A status bit is set only when the pin's mask bit is 0 and its enable bit is 1. A latched edge stays pending while the pin is gated and appears as soon as the gate opens.
- R8: Writing 1 to a bit of the clear register (0x34) removes that pin's latched edge by the next cycle. If a new enabled edge is detected in the same cycle as the clear, the new edge stays latched.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: Writes to the read-only registers (0x14, 0x20, 0x30) have no effect. The write-only registers (0x18, 0x1C, 0x34) and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output latch |
| pin_oe | output | 16 | Per-pin output enable (the direction bits) |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so the bench samples a readback in the same low clock phase it sets the address. Register writes take effect from the first edge after the strobe, and the bench checks them at the next falling edge. Input data and level status are due two edges after a pin change. Edge status is due three edges after a pin change. The bench therefore counts falling edges from each pin change, and for edge mode it confirms that status is still clear at edge two and set at edge three. The case where a clear and a new edge arrive together is driven so that the clear is captured on the same edge that latches the new edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_ADDR_W = 8;

    typedef enum logic [3:0] {
        RSEL_NONE,
        RSEL_DIR,
        RSEL_MODE,
        RSEL_POL,
        RSEL_RISE,
        RSEL_FALL,
        RSEL_IN,
        RSEL_SET,
        RSEL_CLR,
        RSEL_OUT,
        RSEL_MASK,
        RSEL_EN,
        RSEL_STAT,
        RSEL_ACK
    } gpio_reg_e;

    function automatic gpio_reg_e gpio_decode(input logic [GPIO_ADDR_W-1:0] addr);
        gpio_reg_e r;
        case (addr)
            8'h00:   r = RSEL_DIR;
            8'h04:   r = RSEL_MODE;
            8'h08:   r = RSEL_POL;
            8'h0C:   r = RSEL_RISE;
            8'h10:   r = RSEL_FALL;
            8'h14:   r = RSEL_IN;
            8'h18:   r = RSEL_SET;
            8'h1C:   r = RSEL_CLR;
            8'h20:   r = RSEL_OUT;
            8'h28:   r = RSEL_MASK;
            8'h2C:   r = RSEL_EN;
            8'h30:   r = RSEL_STAT;
            8'h34:   r = RSEL_ACK;
            default: r = RSEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];

    generate
        if (STAGES >= 2) begin : g_chk
            // R4
            sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sync_out == $past(stage_q[STAGES-2]));
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_s,
    input  logic [NPINS-1:0] mode_lvl,
    input  logic [NPINS-1:0] pol_hi,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] enable,
    input  logic [NPINS-1:0] ack,
    output logic [NPINS-1:0] stat
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] lat;
    } det_t;

    det_t det_d, det_q;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] lvl_act;
    logic [NPINS-1:0] gate;

    always_comb begin
        hit      = ~mode_lvl & ((rise_en & pin_s & ~det_q.prev) |
                                (fall_en & ~pin_s & det_q.prev));
        lvl_act  = mode_lvl & ~(pin_s ^ pol_hi);
        gate     = enable & ~mask;
        det_d.prev = pin_s;
        det_d.lat  = (det_q.lat & ~ack) | hit;
        stat     = gate & (lvl_act | (~mode_lvl & det_q.lat));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    // R6
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((det_q.lat & $past(hit)) == $past(hit)));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack & ~hit)) |=> ((det_q.lat & $past(ack & ~hit)) == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]       bus_wdata,
    output logic [NPINS-1:0]       bus_rdata,
    input  logic [NPINS-1:0]       in_data,
    input  logic [NPINS-1:0]       stat,
    output logic [NPINS-1:0]       dir_o,
    output logic [NPINS-1:0]       mode_o,
    output logic [NPINS-1:0]       pol_o,
    output logic [NPINS-1:0]       rise_o,
    output logic [NPINS-1:0]       fall_o,
    output logic [NPINS-1:0]       out_o,
    output logic [NPINS-1:0]       mask_o,
    output logic [NPINS-1:0]       en_o,
    output logic [NPINS-1:0]       ack_o
);

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] rise;
        logic [NPINS-1:0] fall;
        logic [NPINS-1:0] outv;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] en;
    } regs_t;

    regs_t     regs_d, regs_q;
    gpio_reg_e rsel;
    logic      wr;

    always_comb begin
        rsel   = gpio_decode(bus_addr);
        wr     = bus_valid & bus_write;
        regs_d = regs_q;
        ack_o  = '0;
        if (wr) begin
            case (rsel)
                RSEL_DIR:  regs_d.dir  = bus_wdata;
                RSEL_MODE: regs_d.mode = bus_wdata;
                RSEL_POL:  regs_d.pol  = bus_wdata;
                RSEL_RISE: regs_d.rise = bus_wdata;
                RSEL_FALL: regs_d.fall = bus_wdata;
                RSEL_SET:  regs_d.outv = regs_q.outv | bus_wdata;
                RSEL_CLR:  regs_d.outv = regs_q.outv & ~bus_wdata;
                RSEL_MASK: regs_d.mask = bus_wdata;
                RSEL_EN:   regs_d.en   = bus_wdata;
                RSEL_ACK:  ack_o       = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (rsel)
            RSEL_DIR:  bus_rdata = regs_q.dir;
            RSEL_MODE: bus_rdata = regs_q.mode;
            RSEL_POL:  bus_rdata = regs_q.pol;
            RSEL_RISE: bus_rdata = regs_q.rise;
            RSEL_FALL: bus_rdata = regs_q.fall;
            RSEL_IN:   bus_rdata = in_data;
            RSEL_OUT:  bus_rdata = regs_q.outv;
            RSEL_MASK: bus_rdata = regs_q.mask;
            RSEL_EN:   bus_rdata = regs_q.en;
            RSEL_STAT: bus_rdata = stat;
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.mask <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_o  = regs_q.dir;
    assign mode_o = regs_q.mode;
    assign pol_o  = regs_q.pol;
    assign rise_o = regs_q.rise;
    assign fall_o = regs_q.fall;
    assign out_o  = regs_q.outv;
    assign mask_o = regs_q.mask;
    assign en_o   = regs_q.en;

    // R3
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rsel == RSEL_SET) |=> ((out_o & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rsel == RSEL_CLR) |=> ((out_o & $past(bus_wdata)) == '0));

    // R10
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (rsel == RSEL_IN || rsel == RSEL_OUT || rsel == RSEL_STAT))
        |=> ($stable(out_o) && $stable(dir_o) && $stable(en_o) && $stable(mask_o)));

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]       bus_wdata,
    output logic [NPINS-1:0]       bus_rdata,
    input  logic [NPINS-1:0]       pin_in,
    output logic [NPINS-1:0]       pin_out,
    output logic [NPINS-1:0]       pin_oe,
    output logic                   irq
);

    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] stat;
    logic [NPINS-1:0] mode, pol, rise, fall, mask, en, ack;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_data   (pin_s),
        .stat      (stat),
        .dir_o     (pin_oe),
        .mode_o    (mode),
        .pol_o     (pol),
        .rise_o    (rise),
        .fall_o    (fall),
        .out_o     (pin_out),
        .mask_o    (mask),
        .en_o      (en),
        .ack_o     (ack)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .mode_lvl (mode),
        .pol_hi   (pol),
        .rise_en  (rise),
        .fall_en  (fall),
        .mask     (mask),
        .enable   (en),
        .ack      (ack),
        .stat     (stat)
    );

    assign irq = |stat;

    // R7
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & (mask | ~en)) == '0);

endmodule

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;

    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {op: 1 = set, 0 = clear, 16-bit data, 16-bit expected latch}
    localparam logic [32:0] OUT_VEC [0:7] = '{
        {1'b1, 16'h00FF, 16'h00FF},
        {1'b0, 16'h000F, 16'h00F0},
        {1'b1, 16'h0F00, 16'h0FF0},
        {1'b0, 16'h0000, 16'h0FF0},
        {1'b1, 16'h8001, 16'h8FF1},
        {1'b0, 16'h0FF0, 16'h8001},
        {1'b1, 16'hFFFF, 16'hFFFF},
        {1'b0, 16'h5555, 16'hAAAA}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [NP-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic chk_stat(input string tag, input logic [NP-1:0] exp);
        logic [NP-1:0] v;
        rd(8'h30, v);
        chk({tag, " status"}, {16'h0, v}, {16'h0, exp});
        chk({tag, " irq R9"}, {31'h0, irq}, {31'h0, |exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
        rd(8'h28, v); chk("R1 mask", {16'h0, v}, 32'hFFFF);
        rd(8'h2C, v); chk("R1 enable", {16'h0, v}, 32'h0);
        chk_stat("R1", 16'h0);

        // R2 direction
        wr(8'h00, 16'h00F3);
        chk("R2 pin_oe", {16'h0, pin_oe}, 32'h00F3);
        rd(8'h00, v); chk("R2 readback", {16'h0, v}, 32'h00F3);
        wr(8'h00, 16'h0000);
        chk("R2 pin_oe cleared", {16'h0, pin_oe}, 32'h0);

        // R3 set/clear table
        for (int i = 0; i < 8; i++) begin
            wr(OUT_VEC[i][32] ? 8'h18 : 8'h1C, OUT_VEC[i][31:16]);
            chk($sformatf("R3 vec%0d pin_out", i), {16'h0, pin_out}, {16'h0, OUT_VEC[i][15:0]});
            rd(8'h20, v);
            chk($sformatf("R3 vec%0d readback", i), {16'h0, v}, {16'h0, OUT_VEC[i][15:0]});
        end

        // R10 read-only and write-only registers
        wr(8'h20, 16'h1234);
        wr(8'h14, 16'hFFFF);
        wr(8'h30, 16'hFFFF);
        chk("R10 pin_out unchanged", {16'h0, pin_out}, 32'hAAAA);
        rd(8'h20, v); chk("R10 out readback", {16'h0, v}, 32'hAAAA);
        rd(8'h18, v); chk("R10 set reads 0", {16'h0, v}, 32'h0);
        rd(8'h34, v); chk("R10 ack reads 0", {16'h0, v}, 32'h0);
        rd(8'h24, v); chk("R10 unmapped", {16'h0, v}, 32'h0);

        // R4 synchroniser latency
        pin_in = 16'hA5C3;
        tick(1);
        rd(8'h14, v); chk("R4 one edge", {16'h0, v}, 32'h0);
        tick(1);
        rd(8'h14, v); chk("R4 two edges", {16'h0, v}, 32'hA5C3);
        pin_in = 16'h0;
        tick(4);

        // open gate, configure edges: pin0 rise, pin1 fall, pin2 both
        wr(8'h28, 16'h0000);
        wr(8'h2C, 16'hFFFF);
        wr(8'h0C, 16'h0005);
        wr(8'h10, 16'h0006);
        chk_stat("R6 idle", 16'h0);

        // R6 rising on pin0, exact latency
        pin_in = 16'h0001;
        tick(2); chk_stat("R6 rise edge2", 16'h0);
        tick(1); chk_stat("R6 rise edge3", 16'h0001);
        wr(8'h34, 16'h0001);
        chk_stat("R8 ack", 16'h0);
        pin_in = 16'h0000;
        tick(4); chk_stat("R6 fall ignored on rise-only pin", 16'h0);

        // R6 falling on pin1
        pin_in = 16'h0002;
        tick(4); chk_stat("R6 rise ignored on fall-only pin", 16'h0);
        pin_in = 16'h0000;
        tick(3); chk_stat("R6 fall", 16'h0002);
        wr(8'h34, 16'h0002);

        // R6 both edges on pin2
        pin_in = 16'h0004;
        tick(3); chk_stat("R6 both rise", 16'h0004);
        wr(8'h34, 16'h0004);
        chk_stat("R8 ack both", 16'h0);
        pin_in = 16'h0000;
        tick(3); chk_stat("R6 both fall", 16'h0004);
        wr(8'h34, 16'h0004);
        chk_stat("R8 ack fall", 16'h0);

        // R8 new edge in the clear cycle stays latched
        pin_in = 16'h0004;
        tick(2);
        wr(8'h34, 16'h0004);
        chk_stat("R8 set wins", 16'h0004);
        wr(8'h34, 16'h0004);
        chk_stat("R8 cleared after", 16'h0);
        pin_in = 16'h0000;
        tick(4);
        wr(8'h34, 16'h0004);

        // R7 gating with pending edge
        wr(8'h28, 16'h0001);
        pin_in = 16'h0001;
        tick(4); chk_stat("R7 masked", 16'h0);
        wr(8'h28, 16'h0000);
        chk_stat("R7 unmasked pending", 16'h0001);
        wr(8'h2C, 16'hFFFE);
        chk_stat("R7 disabled", 16'h0);
        wr(8'h2C, 16'hFFFF);
        wr(8'h34, 16'h0001);
        chk_stat("R7 acked", 16'h0);
        pin_in = 16'h0000;
        tick(4);

        // R5 level: pin4 active-high, pin5 active-low
        wr(8'h08, 16'h0010);
        wr(8'h04, 16'h0030);
        chk_stat("R5 low-active immediate", 16'h0020);
        pin_in = 16'h0030;
        tick(1); chk_stat("R5 edge1", 16'h0020);
        tick(1); chk_stat("R5 edge2", 16'h0010);
        wr(8'h34, 16'h0010);
        chk_stat("R5 not latched", 16'h0010);
        pin_in = 16'h0020;
        tick(2); chk_stat("R5 inactive", 16'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule